// File: doc/BRIEF.md
# Supervisor reset and watchdog timer

This block holds a processor in reset while the supply is bad and for a fixed time after it recovers. It also watches a strobe line that software toggles, and forces a reset pulse when the strobe stops. A comparator outside the block delivers a synchronous supply-good flag. The strobe arrives with a separate flag that marks it as floating. Two mode straps choose the timebase. It can be a prescaled copy of the system clock, counted in milliseconds, or the rising edges of an external tick input.

One tick counter source feeds both the reset-hold counter and the watchdog counter. The watchdog has a long and a short period. The long period is always used for the first timeout after any reset. The short period, when the straps select it, takes effect only after software has toggled the strobe at least once since reset ended. On expiry the block issues one full-length reset pulse and drives an expired flag low. The flag stays low until the next strobe edge or a supply drop.

Top module: `sup_reset_wdog`

## Requirements
- R1: `reset_no` goes low combinationally whenever `supply_ok_i` is 0. After `supply_ok_i` returns to 1 it stays low for the reset period of RST_MS ticks (internal) or RST_CLKS ticks (external), measured from the timebase.
- R2: `line_low_no` equals `supply_ok_i` combinationally, with no register in the path.
- R3: With `osc_int_i`=1 a tick is every CLKS_PER_MS clocks. `wd_long_i`=0 selects a normal watchdog period of WD_SHORT_MS ticks. `wd_long_i`=1 makes every watchdog period WD_LONG_MS ticks.
- R4: With `osc_int_i`=0 a tick is each rising edge of `ext_clk_i` after a two-flop synchronizer. The reset period is RST_CLKS ticks, the normal watchdog period is WD_SHORT_CLKS ticks and the period after a reset is WD_LONG_CLKS ticks.
- R5: The first watchdog period after a reset ends is always the long period. The short period applies only after the first strobe edge seen while reset is inactive.
- R6: Each rising or falling strobe edge, after a two-flop synchronizer, restarts the watchdog count. An edge in the same cycle as the expiring tick wins, and no expiry occurs.
- R7: On expiry a reset pulse of the full reset period starts and `wd_expired_no` goes low. It returns high on the next strobe edge, or when `supply_ok_i` is 0.
- R8: The watchdog count restarts when every reset ends, so a stuck strobe yields a reset pulse after each long period.
- R9: While `wd_float_i`=1 or `supply_ok_i`=0 the watchdog count is held at zero and never expires.
- R10: `reset_o` is always the exact complement of `reset_no`.
- R11: After `rst_ni` is asserted, `reset_no` is low and `wd_expired_no` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block |
| supply_ok_i | input | 1 | Synchronous supply-good flag from the comparator |
| wd_strobe_i | input | 1 | Watchdog strobe toggled by software |
| wd_float_i | input | 1 | Strobe is floating; disables the watchdog |
| osc_int_i | input | 1 | 1: internal prescaled timebase, 0: external ticks |
| wd_long_i | input | 1 | Internal mode only: 1 long period always, 0 short normal period |
| ext_clk_i | input | 1 | External tick input, rising edges counted |
| reset_no | output | 1 | Processor reset, active low |
| reset_o | output | 1 | Processor reset, active high |
| wd_expired_no | output | 1 | Watchdog expired flag, active low |
| line_low_no | output | 1 | Supply below threshold, active low |

## Verification
A strobe edge and the tick that would end the watchdog period can reach the counter in the same cycle. The bench provokes this in external mode. It drives one external tick and one strobe toggle on the same edge, so both pass through synchronizers of equal depth together. The expected result is that reset stays high and the expired flag stays high. The next tick must then only advance the restarted count, and the tick after it must expire. A supply drop during an expired state is judged in the same way: the flag must return high while the reset is forced low.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic {SRC_EXT = 1'b0, SRC_INT = 1'b1} tb_src_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/sup_timebase.sv
module sup_timebase import sup_pkg::*; #(
  parameter int CLKS_PER_MS = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_int_i,
  input  logic ext_clk_i,
  output logic tick_o
);
  localparam int PRE_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;

  tb_src_e src;
  logic    ext_s, ext_d, ext_rise, int_tick;

  assign src = tb_src_e'(osc_int_i);

  sup_sync #(.STAGES(SYNC_STAGES)) i_ext_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_clk_i),
    .q_o   (ext_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_d <= 1'b0;
    else         ext_d <= ext_s;
  end
  assign ext_rise = ext_s & ~ext_d;

  generate
    if (CLKS_PER_MS > 1) begin : g_pre
      logic [PRE_W-1:0] pre_q;
      // free-running so both counters share one phase
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                               pre_q <= '0;
        else if (pre_q == PRE_W'(CLKS_PER_MS - 1)) pre_q <= '0;
        else                                       pre_q <= pre_q + 1'b1;
      end
      assign int_tick = (pre_q == PRE_W'(CLKS_PER_MS - 1));
    end else begin : g_nopre
      assign int_tick = 1'b1;
    end
  endgenerate

  assign tick_o = (src == SRC_INT) ? int_tick : ext_rise;

  p_ext_tick_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src == SRC_EXT) && tick_o |=> ext_d)
    else $error("ext tick without synchronized rising edge");
endmodule

// File: rtl/sup_rstgen.sv
module sup_rstgen #(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             supply_ok_i,
  input  logic             tick_i,
  input  logic             fire_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             active_o
);
  logic             rst_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 1'b1;
      cnt_q <= '0;
    end else if (!supply_ok_i || fire_i) begin
      rst_q <= 1'b1;
      cnt_q <= '0;
    end else if (rst_q && tick_i) begin
      if (cnt_q == len_i - 1'b1) begin
        rst_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // supply loss asserts without waiting for a clock
  assign active_o = rst_q | ~supply_ok_i;

  p_release_on_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_q) |-> $past(tick_i) && $past(supply_ok_i))
    else $error("reset released without a tick");

  p_low_supply_holds_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> rst_q)
    else $error("reset not held after supply loss");
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             edge_i,
  input  logic             float_i,
  input  logic             supply_ok_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] short_len_i,
  input  logic [CNT_W-1:0] long_len_i,
  output logic             fire_o,
  output logic             expired_no
);
  logic [CNT_W-1:0] cnt_q, lim;
  logic             first_q, exp_q, run;

  assign lim    = first_q ? long_len_i : short_len_i;
  assign run    = supply_ok_i & ~float_i & ~hold_i;
  // a coincident strobe edge beats the expiring tick
  assign fire_o = run & tick_i & ~edge_i & (cnt_q == lim - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else if (!supply_ok_i || hold_i) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else if (float_i || fire_o) begin
      cnt_q   <= '0;
    end else if (edge_i) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  exp_q <= 1'b0;
    else if (!supply_ok_i)        exp_q <= 1'b0;
    else if (fire_o)              exp_q <= 1'b1;
    else if (edge_i && !float_i)  exp_q <= 1'b0;
  end

  assign expired_no = ~exp_q;

  p_first_long_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_i) |-> first_q)
    else $error("short period armed at reset release");

  p_hold_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> cnt_q == '0)
    else $error("watchdog count not restarted by reset");

  p_float_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    float_i |=> cnt_q == '0)
    else $error("watchdog counted while floating");

  p_flag_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> expired_no)
    else $error("expired flag kept through supply loss");
endmodule

// File: rtl/sup_reset_wdog.sv
module sup_reset_wdog import sup_pkg::*; #(
  parameter int CLKS_PER_MS   = 1000,
  parameter int RST_MS        = 200,
  parameter int WD_SHORT_MS   = 100,
  parameter int WD_LONG_MS    = 1600,
  parameter int RST_CLKS      = 2048,
  parameter int WD_SHORT_CLKS = 1024,
  parameter int WD_LONG_CLKS  = 4096,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic wd_strobe_i,
  input  logic wd_float_i,
  input  logic osc_int_i,
  input  logic wd_long_i,
  input  logic ext_clk_i,
  output logic reset_no,
  output logic reset_o,
  output logic wd_expired_no,
  output logic line_low_no
);
  localparam int MAX_LEN = max_of(max_of(max_of(RST_MS, WD_LONG_MS), max_of(WD_SHORT_MS, RST_CLKS)),
                                  max_of(WD_SHORT_CLKS, WD_LONG_CLKS));
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic             tick, strobe_s, strobe_d, strobe_edge, fire, rst_act;
  logic [CNT_W-1:0] rst_len, short_len, long_len;

  sup_timebase #(.CLKS_PER_MS(CLKS_PER_MS), .SYNC_STAGES(SYNC_STAGES)) i_timebase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .osc_int_i(osc_int_i),
    .ext_clk_i(ext_clk_i),
    .tick_o   (tick)
  );

  sup_sync #(.STAGES(SYNC_STAGES)) i_strobe_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wd_strobe_i),
    .q_o   (strobe_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_d <= 1'b0;
    else         strobe_d <= strobe_s;
  end
  assign strobe_edge = strobe_s ^ strobe_d;

  always_comb begin
    if (osc_int_i) begin
      rst_len   = CNT_W'(RST_MS);
      long_len  = CNT_W'(WD_LONG_MS);
      short_len = wd_long_i ? CNT_W'(WD_LONG_MS) : CNT_W'(WD_SHORT_MS);
    end else begin
      rst_len   = CNT_W'(RST_CLKS);
      long_len  = CNT_W'(WD_LONG_CLKS);
      short_len = CNT_W'(WD_SHORT_CLKS);
    end
  end

  sup_rstgen #(.CNT_W(CNT_W)) i_rstgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .supply_ok_i(supply_ok_i),
    .tick_i     (tick),
    .fire_i     (fire),
    .len_i      (rst_len),
    .active_o   (rst_act)
  );

  sup_wdog #(.CNT_W(CNT_W)) i_wdog (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .edge_i     (strobe_edge),
    .float_i    (wd_float_i),
    .supply_ok_i(supply_ok_i),
    .hold_i     (rst_act),
    .short_len_i(short_len),
    .long_len_i (long_len),
    .fire_o     (fire),
    .expired_no (wd_expired_no)
  );

  assign reset_no    = ~rst_act;
  assign reset_o     = rst_act;
  assign line_low_no = supply_ok_i;

  p_fire_starts_reset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !reset_no && !wd_expired_no)
    else $error("expiry did not start a reset pulse");
endmodule

// File: tb/test_sup_reset_wdog.sv
module test_sup_reset_wdog;
  localparam int CLK_PERIOD = 10;
  localparam int CPM = 4;
  localparam int RMS = 3, SMS = 2, LMS = 6;
  localparam int RCK = 3, SCK = 2, LCK = 5;
  localparam int T   = 4;  // tick spacing in clocks, both modes

  logic clk = 1'b0, rst_n = 1'b0, ok = 1'b0, strobe = 1'b0, flt = 1'b0;
  logic osc_int = 1'b1, wd_long = 1'b1, ext_man = 1'b0, ext_auto = 1'b0, ext_run = 1'b0;
  logic ext_clk, reset_no, reset_o, wd_expired_no, line_low_no;

  assign ext_clk = ext_run ? ext_auto : ext_man;

  sup_reset_wdog #(
    .CLKS_PER_MS(CPM), .RST_MS(RMS), .WD_SHORT_MS(SMS), .WD_LONG_MS(LMS),
    .RST_CLKS(RCK), .WD_SHORT_CLKS(SCK), .WD_LONG_CLKS(LCK), .SYNC_STAGES(2)
  ) i_sup_reset_wdog (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(ok), .wd_strobe_i(strobe),
    .wd_float_i(flt), .osc_int_i(osc_int), .wd_long_i(wd_long), .ext_clk_i(ext_clk),
    .reset_no(reset_no), .reset_o(reset_o), .wd_expired_no(wd_expired_no),
    .line_low_no(line_low_no)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cmpl_bad = 0;
  bit done = 1'b0;
  int    q_lvl[$], q_mn[$], q_mx[$];
  string q_tag[$];

  task automatic check(input bit cond, input string tag, input int act, input int lo, input int hi);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  // driver side of the scoreboard: one item per reset_no phase
  task automatic push(input int lvl, input int mn, input int mx, input string tag);
    q_lvl.push_back(lvl); q_mn.push_back(mn); q_mx.push_back(mx); q_tag.push_back(tag);
  endtask

  task automatic tick_pulse();
    ext_man = 1'b1;
    repeat (2) @(negedge clk);
    ext_man = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_sim();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial forever begin
    repeat (2) @(negedge clk);
    ext_auto = ext_run ? ~ext_auto : 1'b0;
  end

  // monitor: measure each reset_no phase and compare with the queue
  initial begin
    logic last;
    int   len, lvl, mn, mx;
    string tag;
    @(posedge rst_n);
    last = reset_no;
    len  = 0;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (reset_o !== ~reset_no) cmpl_bad++;
      if (reset_no !== last) begin
        if (q_lvl.size() == 0) begin
          check(1'b0, "R7 unexpected reset_no edge", len, -1, -1);
        end else begin
          lvl = q_lvl.pop_front(); mn = q_mn.pop_front();
          mx = q_mx.pop_front(); tag = q_tag.pop_front();
          check((lvl == int'(last)) && (len >= mn) && (len <= mx), tag, len, mn, mx);
        end
        last = reset_no;
        len  = 1;
      end else begin
        len++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL run watchdog: actual %0d expected %0d", q_lvl.size(), 0);
      finish_sim();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(reset_no == 1'b0 && reset_o == 1'b1, "R11 reset asserted at power-on", int'(reset_no), 0, 0);
    check(wd_expired_no == 1'b1, "R11 expired flag high at power-on", int'(wd_expired_no), 1, 1);
    check(line_low_no == 1'b0, "R2 line-low follows low supply", int'(line_low_no), 0, 0);
    @(negedge clk) rst_n = 1'b1;
    push(0, 10 + (RMS-1)*T - 1, 10 + RMS*T + 4, "R1 power-up reset length");
    repeat (10) @(negedge clk);
    ok = 1'b1;
    #1;
    check(line_low_no == 1'b1, "R2 line-low rises with supply", int'(line_low_no), 1, 1);
    check(reset_no == 1'b0, "R1 reset held after supply returns", int'(reset_no), 0, 0);

    // stuck strobe, internal long
    push(1, (LMS-1)*T, LMS*T + 3, "R3 R5 long timeout after reset");
    push(0, (RMS-1)*T, RMS*T + 3, "R7 watchdog reset pulse length");
    wait (q_lvl.size() == 1);
    @(negedge clk);
    check(wd_expired_no == 1'b0, "R7 flag low after expiry", int'(wd_expired_no), 0, 0);
    push(1, (LMS-1)*T, LMS*T + 3, "R8 restart after watchdog reset");
    push(0, (RMS-1)*T, RMS*T + 3, "R8 repeated reset pulse");
    wait (q_lvl.size() == 0);

    // regular strobing then stuck, long strap
    @(negedge clk);
    push(1, 100, 112, "R3 R6 edges restart count, long kept");
    push(0, (RMS-1)*T, RMS*T + 3, "R7 reset pulse after strobing stops");
    for (int i = 0; i < 10; i++) begin
      repeat (8) @(negedge clk);
      strobe = ~strobe;
      if (i == 1) check(wd_expired_no == 1'b1, "R7 flag cleared by strobe edge", int'(wd_expired_no), 1, 1);
    end
    wait (q_lvl.size() == 0);

    // short strap: long first, short after one edge
    wd_long = 1'b0;
    push(1, (LMS-1)*T, LMS*T + 3, "R5 first timeout long despite short strap");
    push(0, (RMS-1)*T, RMS*T + 3, "R7 reset pulse length");
    wait (q_lvl.size() == 0);
    @(negedge clk);
    push(1, 13, 24, "R3 R5 short period after first edge");
    push(0, (RMS-1)*T, RMS*T + 3, "R7 reset pulse length");
    repeat (8) @(negedge clk);
    strobe = ~strobe;
    wait (q_lvl.size() == 0);

    // floating strobe
    @(negedge clk);
    flt = 1'b1;
    push(1, 118, 131, "R9 no timeout while floating");
    push(0, (RMS-1)*T, RMS*T + 3, "R7 reset pulse length");
    repeat (100) @(negedge clk);
    flt = 1'b0;
    wait (q_lvl.size() == 1);
    @(negedge clk);
    check(wd_expired_no == 1'b0, "R7 flag low after expiry", int'(wd_expired_no), 0, 0);
    wait (q_lvl.size() == 0);

    // supply drop while expired, switch to external ticks
    @(negedge clk);
    push(1, 0, 4, "R1 supply drop ends high phase");
    ok = 1'b0;
    #1;
    check(reset_no == 1'b0, "R1 reset asserted at once on supply drop", int'(reset_no), 0, 0);
    check(line_low_no == 1'b0, "R2 line-low falls with supply", int'(line_low_no), 0, 0);
    osc_int = 1'b0;
    ext_run = 1'b1;
    push(0, 6 + (RCK-1)*T, 6 + RCK*T + 4, "R4 external reset period");
    repeat (2) @(negedge clk);
    check(wd_expired_no == 1'b1, "R7 flag cleared by supply drop", int'(wd_expired_no), 1, 1);
    repeat (4) @(negedge clk);
    ok = 1'b1;
    wait (q_lvl.size() == 0);

    // external long then short
    push(1, (LCK-1)*T, LCK*T + 3, "R4 R5 external long timeout after reset");
    push(0, (RCK-1)*T, RCK*T + 3, "R4 external watchdog reset pulse");
    wait (q_lvl.size() == 0);
    @(negedge clk);
    push(1, 13, 24, "R4 external short timeout");
    push(0, (RCK-1)*T, RCK*T + 3, "R4 external watchdog reset pulse");
    repeat (8) @(negedge clk);
    strobe = ~strobe;
    wait (q_lvl.size() == 0);

    // strobe edge coincident with the expiring tick
    @(negedge clk);
    ext_run = 1'b0;
    repeat (4) @(negedge clk);
    strobe = ~strobe;
    repeat (6) @(negedge clk);
    check(wd_expired_no == 1'b1, "R7 flag cleared by strobe edge", int'(wd_expired_no), 1, 1);
    tick_pulse();
    check(reset_no == 1'b1, "R6 no expiry before limit", int'(reset_no), 1, 1);
    ext_man = 1'b1;
    strobe  = ~strobe;
    repeat (2) @(negedge clk);
    ext_man = 1'b0;
    repeat (2) @(negedge clk);
    check(reset_no == 1'b1, "R6 edge wins over coincident final tick", int'(reset_no), 1, 1);
    check(wd_expired_no == 1'b1, "R6 flag unchanged on coincidence", int'(wd_expired_no), 1, 1);
    tick_pulse();
    check(reset_no == 1'b1, "R6 count restarted by coincident edge", int'(reset_no), 1, 1);
    push(1, 20, 100000, "R6 high phase through coincidence");
    push(0, 8, 20, "R7 reset pulse after restarted count expires");
    tick_pulse();
    ext_run = 1'b1;
    wait (q_lvl.size() == 0);

    repeat (4) @(negedge clk);
    check(cmpl_bad == 0, "R10 reset_o complements reset_no", cmpl_bad, 0, 0);
    done = 1'b1;
    finish_sim();
  end
endmodule